// File: doc/BRIEF.md
# Interleaved Host-to-Device Address Decoder

This block holds a single host-managed memory decoder for a device with local memory. Software programs a 64-bit window base, a 64-bit window size and a control word through 32-bit register writes. Each incoming host access is checked against the window. If it falls inside, the interleave-way bits are removed from the window offset and the result becomes a device address. That address is then checked against the capacity of the device.

The response is registered and appears one cycle after the request. A read that is rejected returns an error. A write that is rejected finishes quietly: no error is raised and the hit flag stays low, so nothing is stored downstream. Writing the control word with its commit bit set performs the commit handshake, which sets a committed status output.

Top module: `hdm_xlate`

## Requirements
- R1: After reset the window base, window size and control word are all zero, `committed` is 0, and `rsp_valid`, `rsp_hit` and `rsp_err` are 0. With the zero window, every access misses.
- R2: The register select codes are 0 base low, 1 base high, 2 size low and 3 size high. Each high register forms bits [63:32] and the matching low register forms bits [31:0] of a 64-bit value.
- R3: An access whose address is below the window base misses.
- R4: An access whose offset (address minus base) is greater than or equal to the window size misses. An offset of size minus 1 is inside the window.
- R5: Select code 4 is the control word. Its bits [3:0] hold the granularity G and bits [7:4] hold the way count W. The device address is the offset's low 8+G bits, ORed with the offset's bits from position 8+G+W upward shifted right by W.
- R6: A device address greater than parameter `CAPACITY` is rejected. A device address equal to `CAPACITY` is accepted.
- R7: A rejected read responds with `rsp_err`=1 and `rsp_hit`=0. A rejected write responds with `rsp_err`=0 and `rsp_hit`=0. An accepted access responds with `rsp_hit`=1, `rsp_err`=0 and the device address on `rsp_addr`.
- R8: A control write with bit 9 (commit) set stores the written value with bit 9 and bit 11 (error) cleared and bit 10 (committed) set. `committed` reflects bit 10. The G and W fields of that same write apply to the next access.
- R9: `rsp_valid` is high exactly in the cycle after a cycle in which `acc_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..4) |
| reg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access request valid |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_addr | input | 64 | Host physical address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Access accepted and translated |
| rsp_err | output | 1 | Rejected read |
| rsp_addr | output | 64 | Device address, zero when not accepted |
| committed | output | 1 | Committed status from the control word |

## Verification
A base or size register assembled with the wrong half shifts the window. Accesses placed one byte below the base, at the last byte of the window and one byte past its end then flip their hit or error result in the very next response. A wrong granularity or way field shows up as a wrong `rsp_addr` on the first access with offset bits set above bit 8. Wrong commit handling appears on `committed` one cycle after the control write. A reset that leaves registers in place is exposed because post-reset accesses still hit.

// File: rtl/hdm_xlate.sv
module hdm_xlate #(
  parameter int AW = 64,
  parameter int DW = 32,
  parameter logic [AW-1:0] CAPACITY = 64'h0000_0000_0100_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_err,
  output logic [AW-1:0] rsp_addr,
  output logic          committed
);
  localparam logic [2:0] SEL_BASE_LO = 3'd0;
  localparam logic [2:0] SEL_BASE_HI = 3'd1;
  localparam logic [2:0] SEL_SIZE_LO = 3'd2;
  localparam logic [2:0] SEL_SIZE_HI = 3'd3;
  localparam logic [2:0] SEL_CTRL    = 3'd4;
  localparam int BIT_COMMIT = 9;
  localparam int BIT_DONE   = 10;
  localparam int BIT_ERR    = 11;
  localparam int SHW        = $clog2(AW);

  logic [DW-1:0] base_lo, base_hi, size_lo, size_hi, ctrl;
  logic [AW-1:0] base, size, offset, lo_mask, dpa;
  logic [SHW:0]  keep_bits, drop_top;
  logic          in_win, accept;

  assign base = {base_hi, base_lo};
  assign size = {size_hi, size_lo};
  assign committed = ctrl[BIT_DONE];

  assign offset    = acc_addr - base;
  assign in_win    = (acc_addr >= base) && (offset < size);
  assign keep_bits = (SHW+1)'(8) + (SHW+1)'(ctrl[3:0]);
  assign drop_top  = keep_bits + (SHW+1)'(ctrl[7:4]);
  assign lo_mask   = ~({AW{1'b1}} << keep_bits);
  assign dpa       = (offset & lo_mask) | ((offset >> drop_top) << keep_bits);
  assign accept    = in_win && (dpa <= CAPACITY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo <= '0;
      base_hi <= '0;
      size_lo <= '0;
      size_hi <= '0;
      ctrl    <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_BASE_LO: base_lo <= reg_wdata;
        SEL_BASE_HI: base_hi <= reg_wdata;
        SEL_SIZE_LO: size_lo <= reg_wdata;
        SEL_SIZE_HI: size_hi <= reg_wdata;
        SEL_CTRL: begin
          ctrl <= reg_wdata;
          if (reg_wdata[BIT_COMMIT]) begin
            ctrl[BIT_COMMIT] <= 1'b0;
            ctrl[BIT_ERR]    <= 1'b0;
            ctrl[BIT_DONE]   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_hit   <= acc_valid && accept;
      rsp_err   <= acc_valid && !accept && !acc_write;
      rsp_addr  <= (acc_valid && accept) ? dpa : '0;
    end
  end
endmodule

module hdm_xlate_chk #(
  parameter int AW = 64,
  parameter int DW = 32,
  parameter logic [AW-1:0] CAPACITY = 64'h0000_0000_0100_0000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_sel,
  input logic [DW-1:0] reg_wdata,
  input logic          acc_valid,
  input logic          acc_write,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_err,
  input logic [AW-1:0] rsp_addr,
  input logic          committed
);
  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  // R9
  no_idle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid && !rsp_hit && !rsp_err);
  // R7
  hit_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_err));
  // R7
  write_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write |=> !rsp_err);
  // R6
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_addr <= CAPACITY);
  // R8
  commit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_sel == 3'd4 && reg_wdata[9] |=> committed);
endmodule

bind hdm_xlate hdm_xlate_chk #(.AW(AW), .DW(DW), .CAPACITY(CAPACITY)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err),
  .rsp_addr(rsp_addr), .committed(committed)
);

// File: tb/sim_hdm_xlate.sv
`timescale 1ns/1ps
module sim_hdm_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [63:0] acc_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_err, committed;
  logic [63:0] rsp_addr;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  hdm_xlate u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_err(rsp_err), .rsp_addr(rsp_addr), .committed(committed)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [63:0] addr;
    logic        wr;
    logic        hit;
    logic        err;
    logic [63:0] dpa;
  } vec_t;

  // window base 0x1_0000_0000, size 0x400_0000, capacity 0x100_0000
  localparam vec_t VECS [11] = '{
    '{32'h00, 64'h1_0000_1234, 1'b0, 1'b1, 1'b0, 64'h1234},    // R5 plain
    '{32'h10, 64'h1_0000_1234, 1'b0, 1'b1, 1'b0, 64'h934},     // R5 W=1
    '{32'h22, 64'h1_0005_6789, 1'b0, 1'b1, 1'b0, 64'h15B89},   // R5 G=2 W=2
    '{32'h00, 64'h0_FFFF_FFFF, 1'b0, 1'b0, 1'b1, 64'h0},       // R3 R2
    '{32'h00, 64'h1_03FF_FFFF, 1'b0, 1'b0, 1'b1, 64'h0},       // R6 over cap
    '{32'h20, 64'h1_03FF_FFFF, 1'b0, 1'b1, 1'b0, 64'hFF_FFFF}, // R4 last byte
    '{32'h20, 64'h1_0400_0000, 1'b0, 1'b0, 1'b1, 64'h0},       // R4 end read
    '{32'h20, 64'h1_0400_0000, 1'b1, 1'b0, 1'b0, 64'h0},       // R7 silent write
    '{32'h00, 64'h1_0100_0000, 1'b0, 1'b1, 1'b0, 64'h100_0000},// R6 equal cap
    '{32'h00, 64'h1_0100_0001, 1'b1, 1'b0, 1'b0, 64'h0},       // R7 R6 write
    '{32'h00, 64'h1_0000_0040, 1'b1, 1'b1, 1'b0, 64'h40}       // R7 write hit
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic access(input logic [63:0] a, input logic wr,
                        input logic ehit, input logic eerr, input logic [63:0] edpa,
                        input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
    check({req, " valid"}, 64'(rsp_valid), 64'd1);
    check({req, " hit"}, 64'(rsp_hit), 64'(ehit));
    check({req, " err"}, 64'(rsp_err), 64'(eerr));
    if (ehit) check({req, " addr"}, rsp_addr, edpa);
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 committed", 64'(committed), 64'd0);
    rst_n = 1'b1;
    access(64'h0, 1'b0, 1'b0, 1'b1, 64'h0, "R1 zero window");
    // R9 idle cycle gives no response
    @(negedge clk);
    check("R9 idle", 64'(rsp_valid), 64'd0);

    wreg(3'd0, 32'h0000_0000);
    wreg(3'd1, 32'h0000_0001);
    wreg(3'd2, 32'h0400_0000);
    wreg(3'd3, 32'h0000_0000);

    foreach (VECS[i]) begin
      wreg(3'd4, VECS[i].ctrl);
      access(VECS[i].addr, VECS[i].wr, VECS[i].hit, VECS[i].err, VECS[i].dpa,
             $sformatf("R5/R7 vec%0d", i));
    end

    // R8 commit: G=1 W=1 apply in same write
    wreg(3'd4, 32'h0000_0211);
    check("R8 committed", 64'(committed), 64'd1);
    access(64'h1_0000_1234, 1'b0, 1'b1, 1'b0, 64'h834, "R8 fields");
    wreg(3'd4, 32'h0000_0000);
    check("R8 plain write clears", 64'(committed), 64'd0);

    // R2 high half of base moves window
    wreg(3'd1, 32'h0000_0002);
    access(64'h1_0000_0040, 1'b0, 1'b0, 1'b1, 64'h0, "R2 old window");
    access(64'h2_0000_0040, 1'b0, 1'b1, 1'b0, 64'h40, "R2 new window");

    // R1 reset in mid-run clears registers
    wreg(3'd4, 32'h0000_0200);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 committed after reset", 64'(committed), 64'd0);
    access(64'h2_0000_0040, 1'b0, 1'b0, 1'b1, 64'h0, "R1 window cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule